// File: doc/BRIEF.md
# Prebias-Safe Startup and Mode Sequencer

This block sequences the power-up of a synchronous step-down converter whose output may already hold charge. After enable, it keeps both power switches off until the soft-start ramp rises above the feedback level, so the converter never pulls a charged output down. The first action once switching is allowed is a short low-side pulse, which refills the high-side driver's bootstrap capacitor.

While the converter runs in a safe startup mode, the block raises the low-side sink current limit one notch at a time through four codes. A fixed window of clock cycles after switching begins, it picks the final operating mode. That mode is either pulse skipping or forced PWM. The choice depends on a configuration bit and on the inductor zero-crossing flag seen in the last cycle of the window.

Deasserting enable drops everything back to the off state. The whole sequence runs again from the start on the next enable.

Top module: `prebias_start_seq`

## Requirements
- R1: While reset is high and after it is released, with enable low, sw_en_o=0, ls_first_o=0, mode_o=0 and sink_code_o=0.
- R2: After the edge that samples en_i high, sw_en_o stays 0 until an edge samples ramp_above_fb_i high. That edge can be no earlier than the edge after the one that sampled enable. sw_en_o rises at the edge that samples the crossing.
- R3: ls_first_o is 1 during the first LS_PULSE_CYCLES (default 4) cycles in which sw_en_o is 1, and 0 afterwards, while sw_en_o stays 1.
- R4: mode_o encoding: 0 is safe startup, 1 is pulse skip, 2 is forced PWM. mode_o is 0 for the first WINDOW_CYCLES (default 4096) cycles of switching. It takes its final value at the WINDOW_CYCLES-th edge after the edge where sw_en_o rose.
- R5: With skip_capable_i=1, the final mode is 1 when zero_cross_i is 1 in the last cycle of the window and 2 when it is 0. zero_cross_i in any other cycle of the window has no effect.
- R6: With skip_capable_i=0, the final mode is 2 whatever zero_cross_i does.
- R7: sink_code_o is 0 while not switching. Once switching starts, it is floor(s/STEP_CYCLES) capped at 3, where s counts the edges since sw_en_o rose (STEP_CYCLES defaults to 32). It holds 3 from cycle 96 on.
- R8: When an edge samples en_i low, all outputs return to their R1 values at that edge and all counters clear. The next enable repeats the full sequence from R2.
- R9: Once switching has started, ramp_above_fb_i has no effect, so sw_en_o stays 1 when the ramp flag falls.
- R10: Once chosen, the mode holds until enable is removed, whatever zero_cross_i does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Converter enable |
| ramp_above_fb_i | input | 1 | Soft-start ramp is above the feedback voltage |
| zero_cross_i | input | 1 | Inductor current has reached zero |
| skip_capable_i | input | 1 | Configuration allows pulse-skip operation |
| sw_en_o | output | 1 | Power switches may operate |
| ls_first_o | output | 1 | Request for the initial low-side on-pulse |
| mode_o | output | 2 | Operating mode: 0 safe startup, 1 skip, 2 forced PWM |
| sink_code_o | output | 2 | Low-side sink current-limit threshold select |

## Verification
The bench sweeps each combination of configuration bit and last-cycle zero-crossing level across several enable-to-crossing delays, including a ramp that is already high at enable. It compares every output on every cycle of the window against a count of the edges since switching began.

Several faults would show up directly. A design that honours the ramp in the enable cycle would switch one cycle early. A design that samples the zero-crossing flag off by one cycle would pick the wrong mode, because the flag is driven to the opposite level on every other cycle. An off-by-one in the step counter would move a sink-code boundary.

A mid-sequence disable followed by a full re-run exposes counters that are not cleared. Dropping the ramp flag after start and toggling the zero-crossing flag after the decision expose a design that still listens to those inputs.

// File: rtl/pbs_pkg.sv
package pbs_pkg;
  typedef enum logic [1:0] {
    MODE_SAFE = 2'd0,
    MODE_SKIP = 2'd1,
    MODE_FPWM = 2'd2
  } op_mode_e;

  typedef enum logic [1:0] {
    ST_OFF   = 2'd0,
    ST_ARMED = 2'd1,
    ST_SOFT  = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_e;
endpackage

// File: rtl/pbs_seq_fsm.sv
module pbs_seq_fsm
  import pbs_pkg::*;
#(
  parameter int WINDOW_CYCLES   = 4096,
  parameter int LS_PULSE_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic ramp_above_fb_i,
  output logic sw_active_n_o,
  output logic decide_o,
  output logic sw_en_o,
  output logic ls_first_o
);
  localparam int CW = $clog2(WINDOW_CYCLES);
  localparam logic [CW-1:0] LAST_CNT  = CW'(WINDOW_CYCLES - 1);
  localparam logic [CW-1:0] PULSE_LIM = CW'(LS_PULSE_CYCLES);

  seq_state_e    state_q, state_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          decide;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    decide  = 1'b0;
    case (state_q)
      ST_OFF:   if (en_i) state_n = ST_ARMED;
      ST_ARMED: if (ramp_above_fb_i) begin
                  state_n = ST_SOFT;
                  cnt_n   = '0;
                end
      ST_SOFT:  if (cnt_q == LAST_CNT) begin
                  state_n = ST_RUN;
                  decide  = 1'b1;
                end else begin
                  cnt_n = cnt_q + CW'(1);
                end
      default:  state_n = ST_RUN;
    endcase
    if (!en_i) begin
      state_n = ST_OFF;
      cnt_n   = '0;
      decide  = 1'b0;
    end
  end

  assign sw_active_n_o = (state_n == ST_SOFT) || (state_n == ST_RUN);
  assign decide_o      = decide;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_OFF;
      cnt_q      <= '0;
      sw_en_o    <= 1'b0;
      ls_first_o <= 1'b0;
    end else begin
      state_q    <= state_n;
      cnt_q      <= cnt_n;
      sw_en_o    <= sw_active_n_o;
      ls_first_o <= (state_n == ST_SOFT) && (cnt_n < PULSE_LIM);
    end
  end

  AST_SW_NEEDS_CROSS: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_en_o) |-> $past(ramp_above_fb_i));                          // R2
  AST_FIRST_IS_LOW: assert property (@(posedge clk) disable iff (rst)
    $rose(sw_en_o) |-> ls_first_o);                                      // R3
  AST_LS_INSIDE_SW: assert property (@(posedge clk) disable iff (rst)
    ls_first_o |-> sw_en_o);                                             // R3
  AST_OFF_ON_DISABLE: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (!sw_en_o && !ls_first_o));                                // R8
  AST_NO_RAMP_DROPOUT: assert property (@(posedge clk) disable iff (rst)
    (sw_en_o && en_i) |=> sw_en_o);                                      // R9
endmodule

// File: rtl/pbs_sink_step.sv
module pbs_sink_step #(
  parameter int NUM_STEPS   = 4,
  parameter int STEP_CYCLES = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic [$clog2(NUM_STEPS)-1:0] code_o
);
  localparam int CODE_W = $clog2(NUM_STEPS);
  localparam int SW     = $clog2(STEP_CYCLES);
  localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(NUM_STEPS - 1);
  localparam logic [SW-1:0]     STEP_END = SW'(STEP_CYCLES - 1);

  logic [SW-1:0] cnt_q;
  logic          run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      code_o <= '0;
      run_q  <= 1'b0;
    end else begin
      run_q <= run_i;
      if (!run_i || !run_q) begin
        cnt_q  <= '0;
        code_o <= '0;
      end else if (code_o != TOP_CODE) begin
        if (cnt_q == STEP_END) begin
          cnt_q  <= '0;
          code_o <= code_o + CODE_W'(1);
        end else begin
          cnt_q <= cnt_q + SW'(1);
        end
      end
    end
  end

  AST_CODE_NO_SKIP: assert property (@(posedge clk) disable iff (rst)
    (run_q && $past(run_q)) |-> ((code_o == $past(code_o)) ||
                                 (code_o == $past(code_o) + CODE_W'(1)))); // R7
  AST_CODE_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run_q |-> (code_o == '0));                                          // R7
endmodule

// File: rtl/pbs_mode_sel.sv
module pbs_mode_sel
  import pbs_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     active_i,
  input  logic     decide_i,
  input  logic     zero_cross_i,
  input  logic     skip_capable_i,
  output op_mode_e mode_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode_o <= MODE_SAFE;
    end else if (!active_i) begin
      mode_o <= MODE_SAFE;
    end else if (decide_i) begin
      mode_o <= (skip_capable_i && zero_cross_i) ? MODE_SKIP : MODE_FPWM;
    end
  end

  AST_PWM_ONLY_CFG: assert property (@(posedge clk) disable iff (rst)
    ($past(decide_i) && $past(active_i) && !$past(skip_capable_i))
      |-> (mode_o == MODE_FPWM));                                        // R6
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    (!$past(decide_i) && $past(active_i)) |-> $stable(mode_o));          // R10
endmodule

// File: rtl/prebias_start_seq.sv
module prebias_start_seq
  import pbs_pkg::*;
#(
  parameter int WINDOW_CYCLES   = 4096,
  parameter int LS_PULSE_CYCLES = 4,
  parameter int SINK_STEPS      = 4,
  parameter int STEP_CYCLES     = 32,
  localparam int SINK_CODE_W    = $clog2(SINK_STEPS)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en_i,
  input  logic                   ramp_above_fb_i,
  input  logic                   zero_cross_i,
  input  logic                   skip_capable_i,
  output logic                   sw_en_o,
  output logic                   ls_first_o,
  output logic [1:0]             mode_o,
  output logic [SINK_CODE_W-1:0] sink_code_o
);
  logic     sw_active_n;
  logic     decide;
  op_mode_e mode;

  pbs_seq_fsm #(
    .WINDOW_CYCLES  (WINDOW_CYCLES),
    .LS_PULSE_CYCLES(LS_PULSE_CYCLES)
  ) u_fsm (
    .clk            (clk),
    .rst            (rst),
    .en_i           (en_i),
    .ramp_above_fb_i(ramp_above_fb_i),
    .sw_active_n_o  (sw_active_n),
    .decide_o       (decide),
    .sw_en_o        (sw_en_o),
    .ls_first_o     (ls_first_o)
  );

  pbs_sink_step #(
    .NUM_STEPS  (SINK_STEPS),
    .STEP_CYCLES(STEP_CYCLES)
  ) u_step (
    .clk   (clk),
    .rst   (rst),
    .run_i (sw_active_n),
    .code_o(sink_code_o)
  );

  pbs_mode_sel u_mode (
    .clk           (clk),
    .rst           (rst),
    .active_i      (sw_active_n),
    .decide_i      (decide),
    .zero_cross_i  (zero_cross_i),
    .skip_capable_i(skip_capable_i),
    .mode_o        (mode)
  );

  assign mode_o = mode;

  AST_MODE_NEEDS_SW: assert property (@(posedge clk) disable iff (rst)
    (mode_o != 2'd0) |-> sw_en_o);                                       // R4
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mode_o != 2'd3);                                                     // R4
endmodule

// File: tb/sim_prebias_start_seq.sv
module sim_prebias_start_seq;
  localparam int CLK_PERIOD = 10;
  localparam int WIN   = 4096;
  localparam int PULSE = 4;
  localparam int STEP  = 32;

  logic clk = 1'b0;
  logic rst, en, ramp, zc, skipc;
  logic sw_en, ls_first;
  logic [1:0] mode, code;
  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  prebias_start_seq u0 (
    .clk(clk), .rst(rst), .en_i(en), .ramp_above_fb_i(ramp),
    .zero_cross_i(zc), .skip_capable_i(skipc),
    .sw_en_o(sw_en), .ls_first_o(ls_first), .mode_o(mode), .sink_code_o(code)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cycles, act, exp);
    end
  endtask

  task automatic chk_idle(string req);
    chk({req, " sw_en"}, int'(sw_en), 0);
    chk({req, " ls_first"}, int'(ls_first), 0);
    chk({req, " mode"}, int'(mode), 0);
    chk({req, " code"}, int'(code), 0);
  endtask

  // Full sequence: delay cycles in the armed state before the crossing.
  task automatic run_case(bit skip_cfg, bit zc_last, int dly);
    int exp_mode;
    exp_mode = (skip_cfg && zc_last) ? 1 : 2;
    @(negedge clk);
    en = 1'b0; ramp = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk_idle("R8");
    en = 1'b1; skipc = skip_cfg; zc = ~zc_last;
    ramp = (dly == 0);
    @(posedge clk);                      // enable edge
    @(negedge clk);
    chk("R2 no switching right after enable", int'(sw_en), 0);
    for (int i = 0; i < dly; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R2 armed, waiting for crossing", int'(sw_en), 0);
      if (i == dly - 1) ramp = 1'b1;
    end
    @(posedge clk);                      // crossing sampled: s = 0 after this
    for (int s = 0; s <= WIN + 4; s++) begin
      @(negedge clk);
      chk("R2/R9 sw_en", int'(sw_en), 1);
      chk("R3 ls_first", int'(ls_first), (s < PULSE) ? 1 : 0);
      chk("R7 sink code", int'(code), (s / STEP > 3) ? 3 : s / STEP);
      if (s < WIN) chk("R4 safe mode during window", int'(mode), 0);
      else if (skip_cfg) chk("R5/R10 final mode", int'(mode), exp_mode);
      else chk("R6/R10 final mode", int'(mode), 2);
      if (s == 10) ramp = 1'b0;          // R9
      if (s == WIN - 1) zc = zc_last;    // R5 only last window cycle counts
      else if (s >= WIN) zc = ~zc;       // R10 toggling after decision
      else zc = ~zc_last;
    end
    @(negedge clk);
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk_idle("R8 after disable");
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 200000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, 200000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; en = 1'b0; ramp = 1'b0; zc = 1'b0; skipc = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk_idle("R1 in reset");
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk_idle("R1 after reset");

    for (int sc = 0; sc < 2; sc++)
      for (int z = 0; z < 2; z++)
        for (int d = 0; d < 3; d++)
          run_case(sc[0], z[0], (d == 2) ? 5 : d);

    // Mid-sequence disable, then a full restart.
    @(negedge clk);
    en = 1'b1; ramp = 1'b1; skipc = 1'b1;
    repeat (60) @(posedge clk);
    @(negedge clk);
    chk("R8 switching before abort", int'(sw_en), 1);
    chk("R8 code advanced before abort", int'(code), 1);
    en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk_idle("R8 abort");
    run_case(1'b1, 1'b1, 2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule